// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block keeps the three registers that limit which exceptions a processor core may take: a one-bit global interrupt mask, an 8-bit base priority threshold and a one-bit fault mask. It combines them with the current execution priority supplied by the core and produces the effective priority. For one candidate exception, given by its kind and its configurable priority, it reports whether that exception may become active. Pending-state tracking and arbitration among several requests happen elsewhere. This block only answers whether the single candidate it is given clears the current masking level.

Priorities are signed, and a smaller number is more urgent. The non-maskable interrupt sits at -2 and hard fault at -1. Configurable exceptions use 0 to 255. The core reports thread mode with no active handler as 256. Privileged software writes the threshold, either unconditionally or through a raise-only form, and sets or clears each one-bit mask with strobes. The exception return strobe clears the fault mask automatically, unless the handler that is returning is the non-maskable one. Masking only holds an exception back from activation. It never prevents the exception from becoming pending.

Top module: `excmask_unit`

## Requirements
- R1: A synchronous active-high reset clears both one-bit masks and the threshold. After reset, an unmasked configurable request with priority 5 is granted while `cur_prio_i` is 256.
- R2: `eff_prio_o` is registered one cycle after its inputs. It equals the minimum of `cur_prio_i`, the threshold when the threshold is nonzero, 0 when the global mask is set, and -1 when the fault mask is set.
- R3: `take_o` is registered one cycle after the request. It is 1 only when `req_valid_i` is high and the request's priority is strictly smaller than the effective priority. The request priority is -2 for kind 2'b10 (non-maskable), -1 for kind 2'b01 (hard fault), and `req_prio_i` for kinds 2'b00 and 2'b11 (configurable).
- R4: While the global mask is set, the effective priority is at most 0. Every configurable request is refused, and hard fault and non-maskable requests are still granted.
- R5: A nonzero threshold refuses configurable requests whose priority is equal to or larger than the threshold. A threshold of zero masks nothing.
- R6: A privileged plain threshold write (`thr_wr_i` high, `thr_raise_i` low) loads `thr_wdata_i` unconditionally, including zero and values that lower the masking level.
- R7: A privileged raise-only write (`thr_wr_i` and `thr_raise_i` high) loads a nonzero `thr_wdata_i` only when the threshold is zero or the new value is strictly smaller. Otherwise the threshold is unchanged, and that includes writes of zero and of an equal value.
- R8: While the fault mask is set, the effective priority is at most -1. Hard fault and configurable requests are refused, and a non-maskable request is still granted.
- R9: An exception return with `exc_ret_nmi_i` low clears the fault mask. A return with `exc_ret_nmi_i` high leaves it unchanged. A privileged fault-mask set in the same cycle as a return takes precedence over the automatic clear.
- R10: While `priv_i` is low, threshold writes and the set and clear strobes of both masks have no effect. The automatic clear of R9 still applies.
- R11: Each one-bit mask is set by its set strobe and cleared by its clear strobe. When both strobes are asserted together, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Core is in privileged state |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_raise_i | input | 1 | Write is raise-only (qualifies `thr_wr_i`) |
| thr_wdata_i | input | PRIO_W | Threshold write value |
| gmask_set_i | input | 1 | Set the global interrupt mask |
| gmask_clr_i | input | 1 | Clear the global interrupt mask |
| fmask_set_i | input | 1 | Set the fault mask |
| fmask_clr_i | input | 1 | Clear the fault mask |
| exc_ret_i | input | 1 | Exception return strobe |
| exc_ret_nmi_i | input | 1 | The returning handler is the non-maskable one |
| cur_prio_i | input | PRIO_W+2 | Current execution priority, signed, 256 in thread mode |
| req_valid_i | input | 1 | Candidate request present |
| req_kind_i | input | 2 | Candidate kind: 00/11 configurable, 01 hard fault, 10 non-maskable |
| req_prio_i | input | PRIO_W | Candidate configurable priority |
| gmask_o | output | 1 | Global interrupt mask state |
| fmask_o | output | 1 | Fault mask state |
| thr_o | output | PRIO_W | Base priority threshold |
| eff_prio_o | output | PRIO_W+2 | Effective priority, signed, registered |
| take_o | output | 1 | Candidate may activate, registered |

## Verification
The bench probes requests at exactly the threshold value and at one step more urgent. A design that compares with less-or-equal would grant the request at the threshold, and one that ignores the threshold would grant both. Raise-only writes of zero, of an equal value and of a less urgent value must all leave the threshold untouched. A design that compares the wrong way, or treats zero as the most urgent value, would corrupt the threshold. The fault mask is checked across returns from an ordinary handler, from the non-maskable handler, and with a set in the same cycle as the return. Getting the exemption or the precedence wrong would leave the mask stuck or drop it. Unprivileged strobes are checked both while the masks are clear and while they are set, so a design that ignores privilege in only one direction is still caught.

// File: rtl/excmask_pkg.sv
package excmask_pkg;
  // Kind of the candidate exception; both 00 and 11 mean configurable.
  typedef enum logic [1:0] {
    EXC_CFG  = 2'b00,
    EXC_HARD = 2'b01,
    EXC_NMI  = 2'b10,
    EXC_CFG2 = 2'b11
  } exc_kind_e;
endpackage

// File: rtl/excmask_regs.sv
module excmask_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_i,
  input  logic              thr_wr_i,
  input  logic              thr_raise_i,
  input  logic [PRIO_W-1:0] thr_wdata_i,
  input  logic              gmask_set_i,
  input  logic              gmask_clr_i,
  input  logic              fmask_set_i,
  input  logic              fmask_clr_i,
  input  logic              exc_ret_i,
  input  logic              exc_ret_nmi_i,
  output logic              gmask_q,
  output logic              fmask_q,
  output logic [PRIO_W-1:0] thr_q
);
  logic raise_ok;
  logic thr_we;
  logic auto_clr;

  // Raise-only: new value must be nonzero and either masking is off or it is more urgent.
  assign raise_ok = (thr_wdata_i != '0) && ((thr_q == '0) || (thr_wdata_i < thr_q));
  assign thr_we   = priv_i && thr_wr_i && (!thr_raise_i || raise_ok);
  assign auto_clr = exc_ret_i && !exc_ret_nmi_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q <= 1'b0;
      fmask_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      if (thr_we) thr_q <= thr_wdata_i;

      if (priv_i && gmask_set_i)      gmask_q <= 1'b1;
      else if (priv_i && gmask_clr_i) gmask_q <= 1'b0;

      if (priv_i && fmask_set_i)                    fmask_q <= 1'b1;
      else if ((priv_i && fmask_clr_i) || auto_clr) fmask_q <= 1'b0;
    end
  end
endmodule

// File: rtl/excmask_prio.sv
module excmask_prio #(
  parameter int PRIO_W = 8
) (
  input  logic signed [PRIO_W+1:0] cur_prio_i,
  input  logic        [PRIO_W-1:0] thr_q,
  input  logic                     gmask_q,
  input  logic                     fmask_q,
  output logic signed [PRIO_W+1:0] eff_prio
);
  localparam int SPW = PRIO_W + 2;
  localparam logic signed [SPW-1:0] LVL_ZERO = '0;
  localparam logic signed [SPW-1:0] LVL_HARD = SPW'(-1);

  logic signed [SPW-1:0] thr_s;
  assign thr_s = $signed({{(SPW-PRIO_W){1'b0}}, thr_q});

  // Layered minimum: each active mask can only pull the level down.
  always_comb begin
    eff_prio = cur_prio_i;
    if ((thr_q != '0) && (thr_s < eff_prio)) eff_prio = thr_s;
    if (gmask_q && (eff_prio > LVL_ZERO))    eff_prio = LVL_ZERO;
    if (fmask_q && (eff_prio > LVL_HARD))    eff_prio = LVL_HARD;
  end
endmodule

// File: rtl/excmask_gate.sv
module excmask_gate #(
  parameter int PRIO_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [PRIO_W+1:0] eff_prio,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_kind_i,
  input  logic [PRIO_W-1:0]        req_prio_i,
  output logic signed [PRIO_W+1:0] eff_prio_o,
  output logic                     take_o
);
  import excmask_pkg::*;

  localparam int SPW = PRIO_W + 2;
  localparam logic signed [SPW-1:0] LVL_NMI    = SPW'(-2);
  localparam logic signed [SPW-1:0] LVL_HARD   = SPW'(-1);
  localparam logic signed [SPW-1:0] LVL_THREAD = SPW'(2 ** PRIO_W);

  logic signed [SPW-1:0] req_lvl;
  logic                  take_d;

  always_comb begin
    case (exc_kind_e'(req_kind_i))
      EXC_NMI:  req_lvl = LVL_NMI;
      EXC_HARD: req_lvl = LVL_HARD;
      default:  req_lvl = $signed({{(SPW-PRIO_W){1'b0}}, req_prio_i});
    endcase
  end

  assign take_d = req_valid_i && (req_lvl < eff_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_prio_o <= LVL_THREAD;
      take_o     <= 1'b0;
    end else begin
      eff_prio_o <= eff_prio;
      take_o     <= take_d;
    end
  end
endmodule

// File: rtl/excmask_unit.sv
module excmask_unit #(
  parameter int PRIO_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     priv_i,
  input  logic                     thr_wr_i,
  input  logic                     thr_raise_i,
  input  logic [PRIO_W-1:0]        thr_wdata_i,
  input  logic                     gmask_set_i,
  input  logic                     gmask_clr_i,
  input  logic                     fmask_set_i,
  input  logic                     fmask_clr_i,
  input  logic                     exc_ret_i,
  input  logic                     exc_ret_nmi_i,
  input  logic signed [PRIO_W+1:0] cur_prio_i,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_kind_i,
  input  logic [PRIO_W-1:0]        req_prio_i,
  output logic                     gmask_o,
  output logic                     fmask_o,
  output logic [PRIO_W-1:0]        thr_o,
  output logic signed [PRIO_W+1:0] eff_prio_o,
  output logic                     take_o
);
  logic signed [PRIO_W+1:0] eff_prio;

  excmask_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .priv_i        (priv_i),
    .thr_wr_i      (thr_wr_i),
    .thr_raise_i   (thr_raise_i),
    .thr_wdata_i   (thr_wdata_i),
    .gmask_set_i   (gmask_set_i),
    .gmask_clr_i   (gmask_clr_i),
    .fmask_set_i   (fmask_set_i),
    .fmask_clr_i   (fmask_clr_i),
    .exc_ret_i     (exc_ret_i),
    .exc_ret_nmi_i (exc_ret_nmi_i),
    .gmask_q       (gmask_o),
    .fmask_q       (fmask_o),
    .thr_q         (thr_o)
  );

  excmask_prio #(.PRIO_W(PRIO_W)) u_prio (
    .cur_prio_i (cur_prio_i),
    .thr_q      (thr_o),
    .gmask_q    (gmask_o),
    .fmask_q    (fmask_o),
    .eff_prio   (eff_prio)
  );

  excmask_gate #(.PRIO_W(PRIO_W)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .eff_prio    (eff_prio),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_prio_i  (req_prio_i),
    .eff_prio_o  (eff_prio_o),
    .take_o      (take_o)
  );
endmodule

// File: rtl/excmask_chk.sv
module excmask_chk #(
  parameter int PRIO_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     priv_i,
  input logic                     thr_wr_i,
  input logic                     thr_raise_i,
  input logic [PRIO_W-1:0]        thr_wdata_i,
  input logic                     fmask_set_i,
  input logic                     exc_ret_i,
  input logic                     exc_ret_nmi_i,
  input logic signed [PRIO_W+1:0] cur_prio_i,
  input logic                     req_valid_i,
  input logic [1:0]               req_kind_i,
  input logic                     gmask_o,
  input logic                     fmask_o,
  input logic [PRIO_W-1:0]        thr_o,
  input logic signed [PRIO_W+1:0] eff_prio_o,
  input logic                     take_o
);
  localparam logic signed [PRIO_W+1:0] NMI_LVL = (PRIO_W+2)'(-2);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!gmask_o && !fmask_o && (thr_o == '0)));

  // R2
  eff_not_above_cur_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (eff_prio_o <= $past(cur_prio_i)));

  // R3
  no_req_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !take_o);

  // R4
  gmask_blocks_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (gmask_o && req_valid_i && (req_kind_i[1] == req_kind_i[0])) |=> !take_o);

  // R7
  raise_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (priv_i && thr_wr_i && thr_raise_i &&
     ((thr_wdata_i == '0) || ((thr_o != '0) && (thr_wdata_i >= thr_o)))) |=> $stable(thr_o));

  // R8
  fmask_blocks_hard_chk: assert property (@(posedge clk) disable iff (rst)
    (fmask_o && req_valid_i && (req_kind_i == 2'b01)) |=> !take_o);

  // R8
  nmi_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && (req_kind_i == 2'b10) && (cur_prio_i > NMI_LVL)) |=> take_o);

  // R9
  ret_clears_fmask_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_ret_i && !exc_ret_nmi_i && !(priv_i && fmask_set_i)) |=> !fmask_o);

  // R10
  unpriv_gmask_chk: assert property (@(posedge clk) disable iff (rst)
    !priv_i |=> $stable(gmask_o));

  // R10
  unpriv_thr_chk: assert property (@(posedge clk) disable iff (rst)
    !priv_i |=> $stable(thr_o));

  // R10
  unpriv_fmask_chk: assert property (@(posedge clk) disable iff (rst)
    (!priv_i && !(exc_ret_i && !exc_ret_nmi_i)) |=> $stable(fmask_o));
endmodule

bind excmask_unit excmask_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .priv_i        (priv_i),
  .thr_wr_i      (thr_wr_i),
  .thr_raise_i   (thr_raise_i),
  .thr_wdata_i   (thr_wdata_i),
  .fmask_set_i   (fmask_set_i),
  .exc_ret_i     (exc_ret_i),
  .exc_ret_nmi_i (exc_ret_nmi_i),
  .cur_prio_i    (cur_prio_i),
  .req_valid_i   (req_valid_i),
  .req_kind_i    (req_kind_i),
  .gmask_o       (gmask_o),
  .fmask_o       (fmask_o),
  .thr_o         (thr_o),
  .eff_prio_o    (eff_prio_o),
  .take_o        (take_o)
);

// File: tb/excmask_unit_bench.sv
module excmask_unit_bench;
  localparam int PRIO_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic priv_i = 1'b1;
  logic thr_wr_i = 1'b0;
  logic thr_raise_i = 1'b0;
  logic [PRIO_W-1:0] thr_wdata_i = '0;
  logic gmask_set_i = 1'b0;
  logic gmask_clr_i = 1'b0;
  logic fmask_set_i = 1'b0;
  logic fmask_clr_i = 1'b0;
  logic exc_ret_i = 1'b0;
  logic exc_ret_nmi_i = 1'b0;
  logic signed [PRIO_W+1:0] cur_prio_i = 10'sd256;
  logic req_valid_i = 1'b0;
  logic [1:0] req_kind_i = 2'b00;
  logic [PRIO_W-1:0] req_prio_i = '0;
  logic gmask_o;
  logic fmask_o;
  logic [PRIO_W-1:0] thr_o;
  logic signed [PRIO_W+1:0] eff_prio_o;
  logic take_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  excmask_unit #(.PRIO_W(PRIO_W)) u_excmask_unit (
    .clk(clk), .rst(rst), .priv_i(priv_i),
    .thr_wr_i(thr_wr_i), .thr_raise_i(thr_raise_i), .thr_wdata_i(thr_wdata_i),
    .gmask_set_i(gmask_set_i), .gmask_clr_i(gmask_clr_i),
    .fmask_set_i(fmask_set_i), .fmask_clr_i(fmask_clr_i),
    .exc_ret_i(exc_ret_i), .exc_ret_nmi_i(exc_ret_nmi_i),
    .cur_prio_i(cur_prio_i), .req_valid_i(req_valid_i),
    .req_kind_i(req_kind_i), .req_prio_i(req_prio_i),
    .gmask_o(gmask_o), .fmask_o(fmask_o), .thr_o(thr_o),
    .eff_prio_o(eff_prio_o), .take_o(take_o)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_thr(int v, bit raise);
    thr_wr_i = 1'b1; thr_raise_i = raise; thr_wdata_i = PRIO_W'(v);
    step();
    thr_wr_i = 1'b0; thr_raise_i = 1'b0;
  endtask

  task automatic strobe(bit gs, bit gc, bit fs, bit fc);
    gmask_set_i = gs; gmask_clr_i = gc; fmask_set_i = fs; fmask_clr_i = fc;
    step();
    gmask_set_i = 1'b0; gmask_clr_i = 1'b0; fmask_set_i = 1'b0; fmask_clr_i = 1'b0;
  endtask

  task automatic ret(bit nmi, bit fset);
    exc_ret_i = 1'b1; exc_ret_nmi_i = nmi; fmask_set_i = fset;
    step();
    exc_ret_i = 1'b0; exc_ret_nmi_i = 1'b0; fmask_set_i = 1'b0;
  endtask

  // One request cycle; results land one register stage later.
  task automatic probe(logic [1:0] kind, int prio, string req, int exp_take, int exp_eff);
    req_valid_i = 1'b1; req_kind_i = kind; req_prio_i = PRIO_W'(prio);
    step();
    req_valid_i = 1'b0;
    check(req, "take", int'(take_o), exp_take);
    check(req, "eff_prio", int'(eff_prio_o), exp_eff);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "gmask", int'(gmask_o), 0);
    check("R1", "fmask", int'(fmask_o), 0);
    check("R1", "thr", int'(thr_o), 0);
    probe(2'b00, 5, "R1", 1, 256);
  endtask

  task automatic t_curprio();
    cur_prio_i = 10'sd10;
    probe(2'b00, 10, "R3", 0, 10);
    probe(2'b11, 9, "R3", 1, 10);
    req_valid_i = 1'b0; req_kind_i = 2'b10;
    step();
    check("R3", "take without valid", int'(take_o), 0);
    cur_prio_i = 10'sd256;
  endtask

  task automatic t_threshold();
    wr_thr(8'h40, 1'b0);
    check("R6", "thr", int'(thr_o), 8'h40);
    probe(2'b00, 8'h40, "R5", 0, 64);
    probe(2'b00, 8'h3F, "R5", 1, 64);
    cur_prio_i = 10'sd16;
    probe(2'b00, 8'h20, "R2", 0, 16);
    cur_prio_i = 10'sd256;
    wr_thr(0, 1'b0);
    check("R6", "thr zero", int'(thr_o), 0);
    probe(2'b00, 8'hFF, "R5", 1, 256);
  endtask

  task automatic t_raise();
    wr_thr(8'h80, 1'b1);
    check("R7", "raise from zero", int'(thr_o), 8'h80);
    wr_thr(8'hA0, 1'b1);
    check("R7", "less urgent ignored", int'(thr_o), 8'h80);
    wr_thr(8'h80, 1'b1);
    check("R7", "equal ignored", int'(thr_o), 8'h80);
    wr_thr(8'h20, 1'b1);
    check("R7", "more urgent taken", int'(thr_o), 8'h20);
    wr_thr(0, 1'b1);
    check("R7", "zero ignored", int'(thr_o), 8'h20);
    wr_thr(8'hC0, 1'b0);
    check("R6", "plain lowers", int'(thr_o), 8'hC0);
    wr_thr(0, 1'b0);
  endtask

  task automatic t_gmask();
    strobe(1'b1, 1'b0, 1'b0, 1'b0);
    check("R11", "gmask set", int'(gmask_o), 1);
    probe(2'b00, 0, "R4", 0, 0);
    probe(2'b01, 0, "R4", 1, 0);
    probe(2'b10, 0, "R4", 1, 0);
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    check("R11", "gmask clear", int'(gmask_o), 0);
    strobe(1'b1, 1'b1, 1'b0, 1'b0);
    check("R11", "gmask set wins", int'(gmask_o), 1);
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fmask();
    strobe(1'b0, 1'b0, 1'b1, 1'b0);
    check("R11", "fmask set", int'(fmask_o), 1);
    probe(2'b01, 0, "R8", 0, -1);
    probe(2'b10, 0, "R8", 1, -1);
    probe(2'b00, 0, "R8", 0, -1);
    ret(1'b0, 1'b0);
    check("R9", "cleared on return", int'(fmask_o), 0);
    strobe(1'b0, 1'b0, 1'b1, 1'b0);
    ret(1'b1, 1'b0);
    check("R9", "kept on nmi return", int'(fmask_o), 1);
    ret(1'b0, 1'b1);
    check("R9", "set beats auto clear", int'(fmask_o), 1);
    strobe(1'b0, 1'b0, 1'b1, 1'b1);
    check("R11", "fmask set wins", int'(fmask_o), 1);
    strobe(1'b0, 1'b0, 1'b0, 1'b1);
    check("R11", "fmask clear", int'(fmask_o), 0);
  endtask

  task automatic t_unpriv();
    priv_i = 1'b0;
    wr_thr(8'h30, 1'b0);
    check("R10", "thr write", int'(thr_o), 0);
    strobe(1'b1, 1'b0, 1'b1, 1'b0);
    check("R10", "gmask set", int'(gmask_o), 0);
    check("R10", "fmask set", int'(fmask_o), 0);
    priv_i = 1'b1;
    strobe(1'b1, 1'b0, 1'b1, 1'b0);
    wr_thr(8'h30, 1'b0);
    priv_i = 1'b0;
    strobe(1'b0, 1'b1, 1'b0, 1'b1);
    check("R10", "gmask clear", int'(gmask_o), 1);
    check("R10", "fmask clear", int'(fmask_o), 1);
    wr_thr(0, 1'b0);
    check("R10", "thr clear", int'(thr_o), 8'h30);
    ret(1'b0, 1'b0);
    check("R9", "unpriv return clears", int'(fmask_o), 0);
    priv_i = 1'b1;
    strobe(1'b0, 1'b1, 1'b0, 1'b0);
    wr_thr(0, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_curprio();
    t_threshold();
    t_raise();
    t_gmask();
    t_fmask();
    t_unpriv();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule